// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps a small floating-point register file in which every register also holds a producer tag. The tag names the reservation station that will deliver that register's next value. A tag of zero means no station is pending on the register, so the stored value is current. Each cycle the issue stage reads two source registers and may rename one destination register. A source whose producer tag is zero returns its value. Any other source returns the producer tag, and the reservation station then waits for that tag to appear on the result bus.

A single result broadcast bus carries a 64-bit value and a 4-bit station tag. Every register whose producer tag equals the broadcast tag takes the value and drops back to tag zero. A rename always overwrites the destination's producer tag. An older in-flight writer to the same register therefore no longer matches, and its broadcast is ignored by that register. Only the youngest writer updates it. This removes write-after-read and write-after-write hazards without stalling.

Source reads forward a broadcast that lands in the same cycle. If a rename and a matching broadcast hit the same register together, the rename wins.

Top module: `rename_status_table`

## Requirements
- R1: After a synchronous active-low reset, every register reads ready (`rdX_ready`=1) with value 0 and tag 0.
- R2: A read of a register whose producer tag is 0, with no same-cycle forwarding, returns `rdX_ready`=1, the stored value and `rdX_tag`=0.
- R3: A read of a register whose producer tag is nonzero, with no matching broadcast in the same cycle, returns `rdX_ready`=0, `rdX_value`=0 and `rdX_tag` equal to the producer tag.
- R4: A rename (`ren_valid`=1, `ren_tag`≠0) sets the producer tag of register `ren_idx` to `ren_tag` from the next cycle on, replacing any older tag.
- R5: A broadcast (`bc_valid`=1, `bc_tag`≠0) writes `bc_data` into every register whose producer tag equals `bc_tag` and clears those tags to 0 in the next cycle, unless the same register is renamed in that cycle.
- R6: A broadcast whose tag differs from a register's current producer tag leaves that register's value and tag unchanged.
- R7: When a rename and a matching broadcast hit the same register in the same cycle, the register keeps the new rename tag afterwards.
- R8: A read of a register whose producer tag equals the tag of a valid nonzero broadcast in the same cycle returns `rdX_ready`=1, `rdX_value`=`bc_data` and `rdX_tag`=0.
- R9: A rename or broadcast carrying tag 0 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request this cycle |
| ren_idx | input | 4 | Destination register being renamed |
| ren_tag | input | 4 | Tag of the newly allocated station (nonzero) |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 4 | Tag of the station producing the result |
| bc_data | input | 64 | Broadcast result value |
| rd0_idx | input | 4 | Source register for read port 0 |
| rd0_ready | output | 1 | Port 0 operand is a value |
| rd0_value | output | 64 | Port 0 value (0 when pending) |
| rd0_tag | output | 4 | Port 0 producer tag (0 when ready) |
| rd1_idx | input | 4 | Source register for read port 1 |
| rd1_ready | output | 1 | Port 1 operand is a value |
| rd1_value | output | 64 | Port 1 value (0 when pending) |
| rd1_tag | output | 4 | Port 1 producer tag (0 when ready) |

## Verification
The bench builds the block with its defaults: 16 registers, 64-bit data and 4-bit tags. With these values all 15 live tags can be held at once, and one tag can be shared by several registers. That makes multi-register broadcasts, stale broadcasts after write-after-write renames, and tag reuse all reachable in a few thousand random cycles. Directed cycles place a rename and a matching broadcast on one register, forward a broadcast into both read ports, and send tag-zero traffic.

// File: rtl/rename_status_pkg.sv
// Package: shared sizes and the reserved tag encoding of the rename status table.
// Assumes tag value 0 is never a live station tag.
package rename_status_pkg;
    localparam int DEF_NUM_REGS = 16;
    localparam int DEF_DATA_W   = 64;
    localparam int DEF_TAG_W    = 4;

    // Result of a source lookup handed to the issue stage.
    typedef struct packed {
        logic                  ready;
        logic [DEF_TAG_W-1:0]  tag;
    } lookup_hdr_t;
endpackage

// File: rtl/rename_status_entry.sv
// Module: one architectural register with its producer tag.
// Updates on a matching broadcast and on a rename aimed at it; a rename wins over a
// same-cycle broadcast for the tag. Assumes tag 0 means "no producer".
module rename_status_entry #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_hit,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic [DATA_W-1:0] value_q,
    output logic [TAG_W-1:0]  tag_q
);
    logic bc_match;
    logic ren_live;

    // Purpose: decide whether the broadcast targets this register's pending producer.
    always_comb begin
        bc_match = bc_valid && (bc_tag != '0) && (tag_q == bc_tag);
        ren_live = ren_hit && (ren_tag != '0);
    end

    // Purpose: hold value and producer tag; rename overrides broadcast clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            tag_q   <= '0;
        end else begin
            if (bc_match) begin
                value_q <= bc_data;
            end
            if (ren_live) begin
                tag_q <= ren_tag;
            end else if (bc_match) begin
                tag_q <= '0;
            end
        end
    end
endmodule

// File: rtl/rename_status_read.sv
// Module: one source read port. Selects a register and returns either its value or
// its producer tag, forwarding a same-cycle matching broadcast as a ready value.
// Assumes the selected index is below NUM_REGS.
module rename_status_read #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 64,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  values,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]   tags,
    input  logic                             bc_valid,
    input  logic [TAG_W-1:0]                 bc_tag,
    input  logic [DATA_W-1:0]                bc_data,
    output logic                             ready,
    output logic [DATA_W-1:0]                value,
    output logic [TAG_W-1:0]                 tag
);
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_val;
    logic              fwd;

    // Purpose: select the register and resolve ready / forwarded / pending.
    always_comb begin
        sel_tag = tags[idx];
        sel_val = values[idx];
        fwd     = bc_valid && (bc_tag != '0) && (sel_tag == bc_tag);
        if (sel_tag == '0) begin
            ready = 1'b1;
            value = sel_val;
            tag   = '0;
        end else if (fwd) begin
            ready = 1'b1;
            value = bc_data;
            tag   = '0;
        end else begin
            ready = 1'b0;
            value = '0;
            tag   = sel_tag;
        end
    end
endmodule

// File: rtl/rename_status_table.sv
// Module: register rename status table. NUM_REGS registers, each with a producer tag;
// one rename port, NUM_RD source read ports, one result broadcast bus.
// Assumes at most one broadcast per cycle and nonzero tags for live stations.
module rename_status_table
    import rename_status_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int TAG_W    = DEF_TAG_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [IDX_W-1:0]  ren_idx,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    input  logic [IDX_W-1:0]  rd0_idx,
    output logic              rd0_ready,
    output logic [DATA_W-1:0] rd0_value,
    output logic [TAG_W-1:0]  rd0_tag,
    input  logic [IDX_W-1:0]  rd1_idx,
    output logic              rd1_ready,
    output logic [DATA_W-1:0] rd1_value,
    output logic [TAG_W-1:0]  rd1_tag
);
    localparam int NUM_RD = 2;

    logic [NUM_REGS-1:0][DATA_W-1:0] reg_vals;
    logic [NUM_REGS-1:0][TAG_W-1:0]  reg_tags;
    logic [NUM_REGS-1:0]             ren_dec;

    logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
    logic [NUM_RD-1:0]               rd_ready;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_value;
    logic [NUM_RD-1:0][TAG_W-1:0]    rd_tag;

    // Purpose: decode the rename destination into a one-hot register select.
    always_comb begin
        ren_dec = '0;
        if (ren_valid) begin
            ren_dec[ren_idx] = 1'b1;
        end
    end

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
            rename_status_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
                .clk      (clk),
                .rst_n    (rst_n),
                .ren_hit  (ren_dec[r]),
                .ren_tag  (ren_tag),
                .bc_valid (bc_valid),
                .bc_tag   (bc_tag),
                .bc_data  (bc_data),
                .value_q  (reg_vals[r]),
                .tag_q    (reg_tags[r])
            );
        end

        for (genvar p = 0; p < NUM_RD; p++) begin : g_read
            rename_status_read #(
                .NUM_REGS (NUM_REGS), .DATA_W (DATA_W), .TAG_W (TAG_W)
            ) u_read (
                .idx      (rd_idx[p]),
                .values   (reg_vals),
                .tags     (reg_tags),
                .bc_valid (bc_valid),
                .bc_tag   (bc_tag),
                .bc_data  (bc_data),
                .ready    (rd_ready[p]),
                .value    (rd_value[p]),
                .tag      (rd_tag[p])
            );
        end
    endgenerate

    // Purpose: map the read-port vectors onto the named ports.
    always_comb begin
        rd_idx[0] = rd0_idx;
        rd_idx[1] = rd1_idx;
        rd0_ready = rd_ready[0];
        rd0_value = rd_value[0];
        rd0_tag   = rd_tag[0];
        rd1_ready = rd_ready[1];
        rd1_value = rd_value[1];
        rd1_tag   = rd_tag[1];
    end
endmodule

// File: rtl/rename_status_table_chk.sv
// Module: assertion checker bound to the rename status table. Observes the ports and
// the per-register producer tags. Assumes the default package sizes for widths.
module rename_status_table_chk #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 64,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            ren_valid,
    input logic [IDX_W-1:0]                ren_idx,
    input logic [TAG_W-1:0]                ren_tag,
    input logic                            bc_valid,
    input logic [TAG_W-1:0]                bc_tag,
    input logic [DATA_W-1:0]               bc_data,
    input logic [IDX_W-1:0]                rd0_idx,
    input logic                            rd0_ready,
    input logic [DATA_W-1:0]               rd0_value,
    input logic [TAG_W-1:0]                rd0_tag,
    input logic [NUM_REGS-1:0][TAG_W-1:0]  tags
);
    // R3: a pending operand carries a nonzero tag and a zeroed value.
    p_pending_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd0_ready |-> (rd0_tag != '0) && (rd0_value == '0));

    // R8: a matching broadcast is forwarded to the read port.
    p_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && bc_tag != '0 && tags[rd0_idx] == bc_tag)
            |-> rd0_ready && rd0_value == bc_data && rd0_tag == '0);

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            // R4 / R7: a live rename sets the tag regardless of a same-cycle broadcast.
            p_rename_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (ren_valid && ren_tag != '0 && ren_idx == IDX_W'(r))
                    |=> tags[r] == $past(ren_tag));

            // R5: a matching broadcast without a rename clears the tag.
            p_bcast_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (bc_valid && bc_tag != '0 && tags[r] == bc_tag &&
                 !(ren_valid && ren_tag != '0 && ren_idx == IDX_W'(r)))
                    |=> tags[r] == '0);

            // R6 / R9: with neither a live rename nor a matching broadcast the tag holds.
            p_tag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!(ren_valid && ren_tag != '0 && ren_idx == IDX_W'(r)) &&
                 !(bc_valid && bc_tag != '0 && tags[r] == bc_tag))
                    |=> $stable(tags[r]));
        end
    endgenerate
endmodule

bind rename_status_table rename_status_table_chk #(
    .NUM_REGS (NUM_REGS), .DATA_W (DATA_W), .TAG_W (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ren_valid (ren_valid),
    .ren_idx   (ren_idx),
    .ren_tag   (ren_tag),
    .bc_valid  (bc_valid),
    .bc_tag    (bc_tag),
    .bc_data   (bc_data),
    .rd0_idx   (rd0_idx),
    .rd0_ready (rd0_ready),
    .rd0_value (rd0_value),
    .rd0_tag   (rd0_tag),
    .tags      (reg_tags)
);

// File: tb/rename_status_table_tb.sv
// Bench: behavioural reference model of the rename status table, compared on every cycle.
module rename_status_table_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ren_valid = 1'b0;
    logic [3:0]  ren_idx = '0;
    logic [3:0]  ren_tag = '0;
    logic        bc_valid = 1'b0;
    logic [3:0]  bc_tag = '0;
    logic [63:0] bc_data = '0;
    logic [3:0]  rd0_idx = '0;
    logic        rd0_ready;
    logic [63:0] rd0_value;
    logic [3:0]  rd0_tag;
    logic [3:0]  rd1_idx = '0;
    logic        rd1_ready;
    logic [63:0] rd1_value;
    logic [3:0]  rd1_tag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [63:0] m_val [NREG];
    logic [3:0]  m_tag [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_status_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_idx(ren_idx), .ren_tag(ren_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .rd0_idx(rd0_idx), .rd0_ready(rd0_ready), .rd0_value(rd0_value), .rd0_tag(rd0_tag),
        .rd1_idx(rd1_idx), .rd1_ready(rd1_ready), .rd1_value(rd1_value), .rd1_tag(rd1_tag)
    );

    // Compare one read port with the model's expectation.
    task automatic check_port(input int port, input logic [3:0] idx, input logic rdy,
                              input logic [63:0] val, input logic [3:0] tg, input string hint);
        logic        e_rdy;
        logic [63:0] e_val;
        logic [3:0]  e_tag;
        string       req;
        bit          fwd;
        fwd = bc_valid && bc_tag != 0 && m_tag[idx] == bc_tag;
        if (m_tag[idx] == 0) begin
            e_rdy = 1'b1; e_val = m_val[idx]; e_tag = 0; req = "R2";
        end else if (fwd) begin
            e_rdy = 1'b1; e_val = bc_data; e_tag = 0; req = "R8";
        end else begin
            e_rdy = 1'b0; e_val = 0; e_tag = m_tag[idx]; req = "R3";
        end
        if (hint != "") req = hint;
        n_checks++;
        if (rdy !== e_rdy || val !== e_val || tg !== e_tag) begin
            n_fail++;
            $display("FAIL %s port%0d reg%0d: got rdy=%0b val=%h tag=%0d exp rdy=%0b val=%h tag=%0d",
                     req, port, idx, rdy, val, tg, e_rdy, e_val, e_tag);
        end
    endtask

    // One cycle: drive at negedge, check reads, then advance the model at posedge.
    task automatic step(input logic rv, input logic [3:0] ri, input logic [3:0] rt,
                        input logic bv, input logic [3:0] bt, input logic [63:0] bd,
                        input logic [3:0] a, input logic [3:0] b, input string hint);
        @(negedge clk);
        ren_valid = rv; ren_idx = ri; ren_tag = rt;
        bc_valid = bv; bc_tag = bt; bc_data = bd;
        rd0_idx = a; rd1_idx = b;
        #1;
        if (rst_n) begin
            check_port(0, a, rd0_ready, rd0_value, rd0_tag, hint);
            check_port(1, b, rd1_ready, rd1_value, rd1_tag, hint);
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin m_val[r] = 0; m_tag[r] = 0; end
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (bv && bt != 0 && m_tag[r] == bt) begin
                    m_val[r] = bd; m_tag[r] = 0;
                end
            end
            if (rv && rt != 0) m_tag[ri] = rt;
        end
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) begin m_val[r] = 0; m_tag[r] = 0; end
        rst_n = 1'b0;
        repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, "");
        rst_n = 1'b1;
        // R1: every register ready and zero after reset.
        for (int r = 0; r < NREG; r += 2) step(0, 0, 0, 0, 0, 0, 4'(r), 4'(r+1), "R1");
        // R4: rename r3 to tag 5, then overwrite with tag 7.
        step(1, 3, 5, 0, 0, 0, 0, 0, "");
        step(1, 3, 7, 0, 0, 0, 3, 3, "R4");
        step(1, 4, 7, 0, 0, 0, 3, 3, "R4");
        // R6: stale broadcast of tag 5 does not touch r3.
        step(0, 0, 0, 1, 5, 64'hDEAD_0005, 3, 4, "R6");
        step(0, 0, 0, 0, 0, 0, 3, 4, "R6");
        // R8 then R5: tag 7 broadcast forwarded now, written to r3 and r4 next cycle.
        step(0, 0, 0, 1, 7, 64'h1234_5678_9ABC_DEF0, 3, 4, "R8");
        step(0, 0, 0, 0, 0, 0, 3, 4, "R5");
        // R7: rename r5 to 9 while its old producer 2 broadcasts.
        step(1, 5, 2, 0, 0, 0, 0, 0, "");
        step(1, 5, 9, 1, 2, 64'hAAAA_BBBB_CCCC_DDDD, 0, 1, "");
        step(0, 0, 0, 0, 0, 0, 5, 5, "R7");
        // R9: tag-0 rename and tag-0 broadcast change nothing.
        step(1, 6, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 6, 0, "");
        step(0, 0, 0, 0, 0, 0, 6, 0, "R9");
        // Random traffic, model compared every cycle (R2, R3, R4, R5, R8 classes).
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] bt;
            bt = ($urandom_range(0, 9) < 7) ? m_tag[$urandom_range(0, NREG-1)]
                                             : 4'($urandom_range(0, 15));
            step($urandom_range(0, 3) != 0, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                 $urandom_range(0, 2) != 0, bt, {$urandom, $urandom},
                 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), "");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: an unfinished run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got running exp finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule